// File: doc/BRIEF.md
# Run-Time Width Adapter with Byte Reordering

This block sits between a queue that only holds 36-bit words and an external port whose width can be changed while running: the full 36 bits, 18 bits or 9 bits. In the outbound direction it takes one word from the queue head and hands it to the port as one, two or four transfers. In the inbound direction it collects one, two or four port transfers into a word and pushes that word into the queue. A 36-bit word is made of four 9-bit bytes. A two-bit reorder select permutes those bytes. An endian select decides which port lanes carry a narrow transfer and whether the most or the least significant part goes first.

Both data paths use valid/ready handshakes. A transfer happens on a rising clock edge where valid and ready are both high. The outbound path asserts `pop_ready` only on the edge that accepts the final port transfer of a word, so a word leaves the queue only after all of its parts have been delivered. The inbound path asserts `push_valid` only while the final part of a word is on offer. On that final part, `wr_ready` follows `push_ready`, so back-pressure from the queue stalls the port without losing the bytes collected so far. All port-side results are combinational from the present inputs and the part counters, so they are valid in the same cycle as the stimulus.

Top module: `bus_match_adapter`

## Requirements
- R1: `size_sel` 00 moves a word in one 36-bit transfer, 01 in two 18-bit transfers, 10 in four 9-bit transfers. Code 11 is kept for other use: `rd_valid`, `wr_ready`, `pop_ready` and `push_valid` all stay low, and the part counters do not move.
- R2: Reorder select (byte 3 = bits 35..27, byte 0 = bits 8..0, word written {b3,b2,b1,b0}): 00 leaves the word as it is; 01 gives {b0,b1,b2,b3}; 10 gives {b1,b0,b3,b2}; 11 gives {b2,b3,b0,b1}. The reorder is applied to the whole word, after the pop for reads and after packing for writes.
- R3: In 18-bit mode the part sits on port bits 35..18 when big-endian and on bits 17..0 when little-endian. On reads the unused lanes are driven to zero. On writes the unused lanes are ignored.
- R4: In 9-bit mode the part sits on port bits 35..27 when big-endian and on bits 8..0 when little-endian. On reads the unused lanes are zero. On writes the unused lanes are ignored.
- R5: Big-endian moves the most significant part of the word first. Little-endian moves the least significant part first. Reads and writes use the same order.
- R6: Size and reorder select are sampled on the first transfer of a word and held until its last transfer. Changes made in the middle of a word have no effect on that word.
- R7: `endian_big` is captured while `rst` is high. Changes to it after reset have no effect.
- R8: Reset throws away a word that is partly unpacked or partly packed. The next word starts at its first part with no leftover bytes.
- R9: `pop_ready` rises only in the cycle that accepts the last port transfer of a word. `push_valid` is high only while the last part is offered. When `push_ready` is low on that part, `wr_ready` is low. A read stalled by `rd_ready` low keeps the same part on offer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| endian_big | input | 1 | Endian select, captured during reset (1 = big) |
| size_sel | input | 2 | Port width code |
| swap_sel | input | 2 | Byte reorder code |
| wr_valid | input | 1 | Port write part valid |
| wr_ready | output | 1 | Port write part accepted |
| wr_data | input | 36 | Port write data |
| push_valid | output | 1 | Packed word valid toward inbound queue |
| push_ready | input | 1 | Inbound queue can take a word |
| push_data | output | 36 | Packed, reordered word |
| pop_valid | input | 1 | Outbound queue head is valid |
| pop_ready | output | 1 | Outbound queue head consumed |
| pop_data | input | 36 | Outbound queue head word |
| rd_valid | output | 1 | Port read part valid |
| rd_ready | input | 1 | Port reader takes the part |
| rd_data | output | 36 | Port read data |

## Verification
Every port-side output (`rd_data`, `rd_valid`, `pop_ready`, `push_data`, `push_valid`, `wr_ready`) is due in the same cycle as the inputs that produce it. The part counters and the held size and reorder selects change only on the rising edge that completes a transfer. The bench therefore drives each part just after a falling edge, checks the outputs 1 ns later, and lets the next rising edge commit the transfer before it drives the following part. The stall, mid-word and reset cases use the same rhythm, so the value checked in any cycle depends only on the edges that came before it.

// File: rtl/bm_pkg.sv
package bm_pkg;
  localparam int unsigned BM_BYTE_W = 9;
  localparam int unsigned BM_LANES  = 4;
  localparam int unsigned BM_WORD_W = BM_BYTE_W * BM_LANES;

  typedef enum logic [1:0] {
    SZ_LONG = 2'b00,
    SZ_WORD = 2'b01,
    SZ_BYTE = 2'b10,
    SZ_RSVD = 2'b11
  } size_e;

  // index of the final part of a word for a given width
  function automatic logic [1:0] last_part(size_e s);
    case (s)
      SZ_WORD: last_part = 2'd1;
      SZ_BYTE: last_part = 2'd3;
      default: last_part = 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/bm_swap.sv
module bm_swap #(
  parameter int unsigned BYTE_W = 9,
  parameter int unsigned LANES  = 4
) (
  input  logic [BYTE_W*LANES-1:0] din,
  input  logic [1:0]              mode,
  output logic [BYTE_W*LANES-1:0] dout
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int unsigned SRC_REV  = LANES - 1 - i;
    localparam int unsigned SRC_HALF = i ^ (LANES / 2);
    localparam int unsigned SRC_PAIR = i ^ 1;
    always_comb begin
      case (mode)
        2'b01:   dout[i*BYTE_W +: BYTE_W] = din[SRC_REV*BYTE_W  +: BYTE_W];
        2'b10:   dout[i*BYTE_W +: BYTE_W] = din[SRC_HALF*BYTE_W +: BYTE_W];
        2'b11:   dout[i*BYTE_W +: BYTE_W] = din[SRC_PAIR*BYTE_W +: BYTE_W];
        default: dout[i*BYTE_W +: BYTE_W] = din[i*BYTE_W +: BYTE_W];
      endcase
    end
  end
endmodule

// File: rtl/bm_unpack.sv
module bm_unpack
  import bm_pkg::*;
#(
  parameter int unsigned BYTE_W = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                be,
  input  logic [1:0]          size_sel,
  input  logic [1:0]          swap_sel,
  input  logic                q_valid,
  input  logic [4*BYTE_W-1:0] q_data,
  output logic                q_ready,
  output logic                p_valid,
  input  logic                p_ready,
  output logic [4*BYTE_W-1:0] p_data
);
  localparam int unsigned WORD_W = 4 * BYTE_W;
  localparam int unsigned HALF_W = 2 * BYTE_W;

  logic [1:0]        idx_q;
  size_e             size_q;
  logic [1:0]        swap_q;
  size_e             cur_size;
  logic [1:0]        cur_swap;
  logic [1:0]        lp;
  logic [1:0]        part;
  logic              last;
  logic              fire;
  logic [WORD_W-1:0] swapped;
  logic [HALF_W-1:0] half;
  logic [BYTE_W-1:0] byt;

  assign cur_size = (idx_q == 2'd0) ? size_e'(size_sel) : size_q;
  assign cur_swap = (idx_q == 2'd0) ? swap_sel : swap_q;
  assign lp       = last_part(cur_size);
  assign last     = (idx_q == lp);
  assign part     = be ? (lp - idx_q) : idx_q;

  bm_swap #(.BYTE_W(BYTE_W), .LANES(4)) u_swap (
    .din (q_data),
    .mode(cur_swap),
    .dout(swapped)
  );

  assign p_valid = q_valid && (cur_size != SZ_RSVD);
  assign fire    = p_valid && p_ready;
  assign q_ready = fire && last;

  always_comb begin
    half = part[0] ? swapped[WORD_W-1:HALF_W] : swapped[HALF_W-1:0];
    case (part)
      2'd0:    byt = swapped[BYTE_W-1:0];
      2'd1:    byt = swapped[2*BYTE_W-1:BYTE_W];
      2'd2:    byt = swapped[3*BYTE_W-1:2*BYTE_W];
      default: byt = swapped[WORD_W-1:3*BYTE_W];
    endcase
    p_data = '0;
    case (cur_size)
      SZ_LONG: p_data = swapped;
      SZ_WORD: begin
        if (be) p_data[WORD_W-1:HALF_W] = half;
        else    p_data[HALF_W-1:0]      = half;
      end
      SZ_BYTE: begin
        if (be) p_data[WORD_W-1:WORD_W-BYTE_W] = byt;
        else    p_data[BYTE_W-1:0]             = byt;
      end
      default: p_data = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= 2'd0;
      size_q <= SZ_LONG;
      swap_q <= 2'b00;
    end else if (fire) begin
      if (idx_q == 2'd0) begin
        size_q <= cur_size;
        swap_q <= cur_swap;
      end
      idx_q <= last ? 2'd0 : idx_q + 2'd1;
    end
  end

  // a word in progress always has a narrow, legal width
  assert_mid_word_width_R1: assert property (@(posedge clk) disable iff (rst)
    (idx_q != 2'd0) |-> (size_q == SZ_WORD || size_q == SZ_BYTE));

  // held selects do not move until the word finishes
  assert_held_selects_R6: assert property (@(posedge clk) disable iff (rst)
    (idx_q != 2'd0) |=> (idx_q == 2'd0) || ($stable(size_q) && $stable(swap_q)));

  // a stalled reader keeps the same part
  assert_stall_holds_part_R9: assert property (@(posedge clk) disable iff (rst)
    (p_valid && !p_ready) |=> $stable(idx_q));

  assert_reset_restarts_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (idx_q == 2'd0));
endmodule

// File: rtl/bm_pack.sv
module bm_pack
  import bm_pkg::*;
#(
  parameter int unsigned BYTE_W = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                be,
  input  logic [1:0]          size_sel,
  input  logic [1:0]          swap_sel,
  input  logic                p_valid,
  output logic                p_ready,
  input  logic [4*BYTE_W-1:0] p_data,
  output logic                q_valid,
  input  logic                q_ready,
  output logic [4*BYTE_W-1:0] q_data
);
  localparam int unsigned WORD_W = 4 * BYTE_W;
  localparam int unsigned HALF_W = 2 * BYTE_W;

  logic [1:0]        idx_q;
  size_e             size_q;
  logic [1:0]        swap_q;
  logic [WORD_W-1:0] acc_q;
  size_e             cur_size;
  logic [1:0]        cur_swap;
  logic [1:0]        lp;
  logic [1:0]        part;
  logic              last;
  logic              legal;
  logic              fire;
  logic [HALF_W-1:0] in_half;
  logic [BYTE_W-1:0] in_byte;
  logic [WORD_W-1:0] merged;

  assign cur_size = (idx_q == 2'd0) ? size_e'(size_sel) : size_q;
  assign cur_swap = (idx_q == 2'd0) ? swap_sel : swap_q;
  assign lp       = last_part(cur_size);
  assign last     = (idx_q == lp);
  assign part     = be ? (lp - idx_q) : idx_q;
  assign legal    = (cur_size != SZ_RSVD);

  assign in_half = be ? p_data[WORD_W-1:HALF_W] : p_data[HALF_W-1:0];
  assign in_byte = be ? p_data[WORD_W-1:WORD_W-BYTE_W] : p_data[BYTE_W-1:0];

  always_comb begin
    merged = acc_q;
    case (cur_size)
      SZ_LONG: merged = p_data;
      SZ_WORD: begin
        if (part[0]) merged[WORD_W-1:HALF_W] = in_half;
        else         merged[HALF_W-1:0]      = in_half;
      end
      SZ_BYTE: begin
        case (part)
          2'd0:    merged[BYTE_W-1:0]          = in_byte;
          2'd1:    merged[2*BYTE_W-1:BYTE_W]   = in_byte;
          2'd2:    merged[3*BYTE_W-1:2*BYTE_W] = in_byte;
          default: merged[WORD_W-1:3*BYTE_W]   = in_byte;
        endcase
      end
      default: merged = acc_q;
    endcase
  end

  bm_swap #(.BYTE_W(BYTE_W), .LANES(4)) u_swap (
    .din (merged),
    .mode(cur_swap),
    .dout(q_data)
  );

  assign q_valid = p_valid && legal && last;
  assign p_ready = legal && (!last || q_ready);
  assign fire    = p_valid && p_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= 2'd0;
      size_q <= SZ_LONG;
      swap_q <= 2'b00;
      acc_q  <= '0;
    end else if (fire) begin
      if (idx_q == 2'd0) begin
        size_q <= cur_size;
        swap_q <= cur_swap;
      end
      idx_q <= last ? 2'd0 : idx_q + 2'd1;
      acc_q <= last ? '0 : merged;
    end
  end

  // queue back-pressure reaches the port on the final part
  assert_push_stall_R9: assert property (@(posedge clk) disable iff (rst)
    (q_valid && !q_ready) |-> !p_ready);

  // a pushed word leaves nothing behind
  assert_push_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (q_valid && q_ready) |=> (idx_q == 2'd0) && (acc_q == '0));

  assert_reset_empty_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (idx_q == 2'd0) && (acc_q == '0));

  assert_held_selects_R6: assert property (@(posedge clk) disable iff (rst)
    (idx_q != 2'd0) |=> (idx_q == 2'd0) || ($stable(size_q) && $stable(swap_q)));
endmodule

// File: rtl/bus_match_adapter.sv
module bus_match_adapter
  import bm_pkg::*;
#(
  parameter int unsigned BYTE_W = BM_BYTE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                endian_big,
  input  logic [1:0]          size_sel,
  input  logic [1:0]          swap_sel,
  input  logic                wr_valid,
  output logic                wr_ready,
  input  logic [4*BYTE_W-1:0] wr_data,
  output logic                push_valid,
  input  logic                push_ready,
  output logic [4*BYTE_W-1:0] push_data,
  input  logic                pop_valid,
  output logic                pop_ready,
  input  logic [4*BYTE_W-1:0] pop_data,
  output logic                rd_valid,
  input  logic                rd_ready,
  output logic [4*BYTE_W-1:0] rd_data
);
  logic be_q;

  // endian choice is taken only while reset is held
  always_ff @(posedge clk) begin
    if (rst) be_q <= endian_big;
  end

  bm_pack #(.BYTE_W(BYTE_W)) u_pack (
    .clk     (clk),
    .rst     (rst),
    .be      (be_q),
    .size_sel(size_sel),
    .swap_sel(swap_sel),
    .p_valid (wr_valid),
    .p_ready (wr_ready),
    .p_data  (wr_data),
    .q_valid (push_valid),
    .q_ready (push_ready),
    .q_data  (push_data)
  );

  bm_unpack #(.BYTE_W(BYTE_W)) u_unpack (
    .clk     (clk),
    .rst     (rst),
    .be      (be_q),
    .size_sel(size_sel),
    .swap_sel(swap_sel),
    .q_valid (pop_valid),
    .q_data  (pop_data),
    .q_ready (pop_ready),
    .p_valid (rd_valid),
    .p_ready (rd_ready),
    .p_data  (rd_data)
  );

  assert_endian_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(be_q));
endmodule

// File: tb/bus_match_adapter_tb_top.sv
module bus_match_adapter_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        endian_big = 1'b1;
  logic [1:0]  size_sel = 2'b00;
  logic [1:0]  swap_sel = 2'b00;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [35:0] wr_data = '0;
  logic        push_valid;
  logic        push_ready = 1'b1;
  logic [35:0] push_data;
  logic        pop_valid = 1'b0;
  logic        pop_ready;
  logic [35:0] pop_data = '0;
  logic        rd_valid;
  logic        rd_ready = 1'b0;
  logic [35:0] rd_data;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  bus_match_adapter dut_i (
    .clk(clk), .rst(rst), .endian_big(endian_big),
    .size_sel(size_sel), .swap_sel(swap_sel),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .push_valid(push_valid), .push_ready(push_ready), .push_data(push_data),
    .pop_valid(pop_valid), .pop_ready(pop_ready), .pop_data(pop_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // byte reorder model, bytes {b3,b2,b1,b0}
  function automatic logic [35:0] m_swap(logic [35:0] w, logic [1:0] m);
    logic [8:0] b3, b2, b1, b0;
    {b3, b2, b1, b0} = w;
    case (m)
      2'b01:   return {b0, b1, b2, b3};
      2'b10:   return {b1, b0, b3, b2};
      2'b11:   return {b2, b3, b0, b1};
      default: return w;
    endcase
  endfunction

  function automatic int n_of(logic [1:0] sz);
    return (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
  endfunction

  // port image of transfer k of word s
  function automatic logic [35:0] m_lane(logic [35:0] s, logic [1:0] sz, logic be, int k);
    int n = n_of(sz);
    int p = be ? (n - 1 - k) : k;
    logic [17:0] h;
    logic [8:0]  b;
    if (sz == 2'b00) return s;
    if (sz == 2'b01) begin
      h = (p == 1) ? s[35:18] : s[17:0];
      return be ? {h, 18'h0} : {18'h0, h};
    end
    b = s[p*9 +: 9];
    return be ? {b, 27'h0} : {27'h0, b};
  endfunction

  task automatic do_reset(input logic be);
    @(negedge clk);
    rst = 1'b1; endian_big = be;
    wr_valid = 0; pop_valid = 0; rd_ready = 0; push_ready = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // read one word; stop>=0 quits after that many parts; mess alters selects mid-word
  task automatic rd_word(input logic [35:0] w, input logic [1:0] sz, input logic [1:0] sw,
                         input logic be, input string req, input int stop, input bit mess);
    int n = n_of(sz);
    for (int k = 0; k < n; k++) begin
      if (stop >= 0 && k == stop) break;
      @(negedge clk);
      pop_valid = 1; pop_data = w; rd_ready = 1;
      if (k == 0) begin size_sel = sz; swap_sel = sw; end
      else if (mess) begin size_sel = 2'b00; swap_sel = ~sw; end
      #1;
      chk(rd_valid === 1'b1, req, {35'h0, rd_valid}, 36'h1);
      chk(rd_data === m_lane(m_swap(w, sw), sz, be, k), req, rd_data, m_lane(m_swap(w, sw), sz, be, k));
      chk(pop_ready === (k == n - 1), req, {35'h0, pop_ready}, {35'h0, k == n - 1});
    end
    @(negedge clk);
    pop_valid = 0; rd_ready = 0;
  endtask

  task automatic wr_word(input logic [35:0] w, input logic [1:0] sz, input logic [1:0] sw,
                         input logic be, input string req, input int stop, input bit mess);
    int n = n_of(sz);
    for (int k = 0; k < n; k++) begin
      if (stop >= 0 && k == stop) break;
      @(negedge clk);
      wr_valid = 1; push_ready = 1;
      // unused lanes carry junk that must be ignored
      wr_data = m_lane(w, sz, be, k) | (36'h5A5A5A5A5 & ~m_lane(36'hFFFFFFFFF, sz, be, k));
      if (k == 0) begin size_sel = sz; swap_sel = sw; end
      else if (mess) begin size_sel = 2'b00; swap_sel = ~sw; end
      #1;
      chk(wr_ready === 1'b1, req, {35'h0, wr_ready}, 36'h1);
      chk(push_valid === (k == n - 1), req, {35'h0, push_valid}, {35'h0, k == n - 1});
      if (k == n - 1) chk(push_data === m_swap(w, sw), req, push_data, m_swap(w, sw));
    end
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic t_reset_state;
    do_reset(1'b1);
    #1;
    chk(rd_valid === 1'b0, "R9 reset", {35'h0, rd_valid}, 36'h0);
    chk(push_valid === 1'b0, "R9 reset", {35'h0, push_valid}, 36'h0);
    chk(pop_ready === 1'b0, "R9 reset", {35'h0, pop_ready}, 36'h0);
  endtask

  task automatic t_long_swaps(input logic be);
    for (int m = 0; m < 4; m++) begin
      rd_word(36'h123456789 + 36'(m), 2'b00, 2'(m), be, "R2 R1 long read", -1, 0);
      wr_word(36'hABCDEF012 ^ 36'(m), 2'b00, 2'(m), be, "R2 R1 long write", -1, 0);
    end
  endtask

  task automatic t_narrow(input logic be);
    for (int m = 0; m < 4; m++) begin
      rd_word(36'h8F0E1D2C3, 2'b01, 2'(m), be, "R3 R5 word read", -1, 0);
      wr_word(36'h3C4B5A697, 2'b01, 2'(m), be, "R3 R5 word write", -1, 0);
      rd_word(36'hFEDCBA987, 2'b10, 2'(m), be, "R4 R5 byte read", -1, 0);
      wr_word(36'h135792468, 2'b10, 2'(m), be, "R4 R5 byte write", -1, 0);
    end
  endtask

  task automatic t_midword;
    rd_word(36'h0A1B2C3D4, 2'b10, 2'b01, 1'b0, "R6 read", -1, 1);
    wr_word(36'h9E8D7C6B5, 2'b10, 2'b10, 1'b0, "R6 write", -1, 1);
    rd_word(36'h246813579, 2'b01, 2'b11, 1'b0, "R6 read word", -1, 1);
  endtask

  task automatic t_endian_frozen;
    @(negedge clk); endian_big = 1'b1;
    rd_word(36'h1F2E3D4C5, 2'b10, 2'b00, 1'b0, "R7 read", -1, 0);
    wr_word(36'h5C4D3E2F1, 2'b01, 2'b00, 1'b0, "R7 write", -1, 0);
    @(negedge clk); endian_big = 1'b0;
  endtask

  task automatic t_reserved;
    @(negedge clk);
    size_sel = 2'b11; pop_valid = 1; pop_data = 36'h777777777; rd_ready = 1;
    wr_valid = 1; wr_data = 36'h111111111; push_ready = 1;
    #1;
    chk(rd_valid === 1'b0, "R1 reserved", {35'h0, rd_valid}, 36'h0);
    chk(pop_ready === 1'b0, "R1 reserved", {35'h0, pop_ready}, 36'h0);
    chk(wr_ready === 1'b0, "R1 reserved", {35'h0, wr_ready}, 36'h0);
    chk(push_valid === 1'b0, "R1 reserved", {35'h0, push_valid}, 36'h0);
    @(negedge clk);
    pop_valid = 0; rd_ready = 0; wr_valid = 0;
    // counters must still be at the first part
    rd_word(36'h0BADC0DE1, 2'b01, 2'b00, 1'b0, "R1 after reserved", -1, 0);
    wr_word(36'h0FEEDBEE2, 2'b01, 2'b00, 1'b0, "R1 after reserved", -1, 0);
  endtask

  task automatic t_reset_partial;
    wr_word(36'h3FFFFFFFF, 2'b10, 2'b00, 1'b0, "R8 partial", 2, 0);
    rd_word(36'h2AAAAAAAA, 2'b01, 2'b00, 1'b0, "R8 partial", 1, 0);
    do_reset(1'b0);
    wr_word(36'h00000000F, 2'b10, 2'b00, 1'b0, "R8 fresh pack", -1, 0);
    rd_word(36'h155555555, 2'b01, 2'b00, 1'b0, "R8 fresh unpack", -1, 0);
  endtask

  task automatic t_backpressure;
    logic [35:0] w = 36'h6789ABCDE;
    // write: final part stalls on queue
    @(negedge clk);
    size_sel = 2'b01; swap_sel = 2'b00; wr_valid = 1; push_ready = 1;
    wr_data = m_lane(w, 2'b01, 1'b0, 0);
    @(negedge clk);
    wr_data = m_lane(w, 2'b01, 1'b0, 1); push_ready = 0;
    #1;
    chk(wr_ready === 1'b0, "R9 push stall", {35'h0, wr_ready}, 36'h0);
    chk(push_valid === 1'b1, "R9 push stall", {35'h0, push_valid}, 36'h1);
    @(negedge clk);
    push_ready = 1;
    #1;
    chk(push_data === w, "R9 push after stall", push_data, w);
    chk(wr_ready === 1'b1, "R9 push after stall", {35'h0, wr_ready}, 36'h1);
    @(negedge clk);
    wr_valid = 0;
    // read: reader stall keeps first byte
    @(negedge clk);
    size_sel = 2'b10; pop_valid = 1; pop_data = w; rd_ready = 0;
    #1;
    chk(pop_ready === 1'b0, "R9 read stall", {35'h0, pop_ready}, 36'h0);
    @(negedge clk);
    rd_ready = 1;
    #1;
    chk(rd_data === m_lane(w, 2'b10, 1'b0, 0), "R9 read stall part", rd_data, m_lane(w, 2'b10, 1'b0, 0));
    @(negedge clk);
    pop_valid = 0; rd_ready = 0;
  endtask

  initial begin
    t_reset_state();
    t_long_swaps(1'b1);
    t_narrow(1'b1);
    do_reset(1'b0);
    t_long_swaps(1'b0);
    t_narrow(1'b0);
    t_midword();
    t_endian_frozen();
    t_reserved();
    t_reset_partial();
    t_backpressure();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule